// File: doc/BRIEF.md
# Remote Terminal Reply Sequencer with Response Fault Injection

This block times the reply of a remote terminal on a dual-redundant serial command/response bus, and it can be told to get that timing wrong on purpose. A command decoder pulses `cmd_valid` when a command to this terminal ends. The pulse marks the mid-parity crossing of the command's last bit. Along with it come the bus the command came in on, the terminal's own address, the expected data word count and the status flag bits. The fault descriptor is the set of `flt_*` inputs, selected outside the block by terminal address and subaddress. It is sampled in the same cycle. The block latches all of this. It then strobes `tx_start` once for each word that a downstream Manchester encoder should send. Index 0 is the status word and indices 1..N are data words. Bus select, word index and status word are held for the whole reply.

The faults can move the response time from 2 to 30 µs and add 1 to 3 µs of dead time after one chosen word. They can change the data word count by -32 to +1 words. They can put a false address into the status word, send the reply on the other bus, or suppress the reply on bus A, on bus B or on both. All timing is counted in microsecond ticks. A divider makes these ticks from the system clock and restarts it on every accepted command.

The sequencer has four states. ST_IDLE waits for a command. ST_RESP_WAIT counts out the response time. ST_EMIT lasts one cycle and strobes one word. ST_WORD_WAIT counts out one word period plus any dead time. The transitions are as follows. Accept goes from ST_IDLE to ST_RESP_WAIT, unless the command's bus is silenced, in which case the block stays in ST_IDLE. Response expiry goes from ST_RESP_WAIT to ST_EMIT. Word step goes from ST_EMIT to ST_WORD_WAIT while words remain. Word expiry goes from ST_WORD_WAIT to ST_EMIT. Reply done goes from ST_EMIT to ST_IDLE after the last word.

Top module: `rt_reply_fault_ctl`

## Requirements
- R1: After reset, `tx_busy`, `tx_start` and `tx_idx` are all 0, and `tx_start` never rises while `tx_busy` is low.
- R2: With `flt_late_en` low, the first `tx_start` (status word, `tx_idx`=0) comes exactly NOMINAL_US×TICK_DIV+1 clock cycles after the cycle in which `cmd_valid` was high. The default NOMINAL_US is 6.
- R3: With `flt_late_en` high, the response time is `flt_late_us` µs in place of NOMINAL_US. Values below 2 act as 2 and the value 31 acts as 30. The first strobe comes at that count ×TICK_DIV+1 cycles.
- R4: Consecutive `tx_start` strobes are WORD_US×TICK_DIV cycles apart when no dead time applies.
- R5: `flt_gap_sel` (0 = none, 1/2/3 = that many µs) adds dead time only between word `flt_gap_pos` and word `flt_gap_pos`+1. That spacing grows by `flt_gap_sel`×TICK_DIV cycles.
- R6: Data words sent equal the expected count plus `flt_wc_adj` (6-bit two's complement). `exp_wc`=0 means 32. Adjustments above +1 act as +1. The reply is the status word followed by that many data words.
- R7: When the adjusted count would be below zero, only the status word is sent.
- R8: `tx_status[15:11]` holds `flt_addr_val` when `flt_addr_en` is high and `own_addr` otherwise. `tx_status[10:0]` holds `status_flags`.
- R9: A command arriving on bus A (`cmd_bus`=0) with `flt_silent_a` set, or on bus B (`cmd_bus`=1) with `flt_silent_b` set, produces no strobe and no busy. A silence flag for the other bus has no effect.
- R10: `tx_bus` equals `cmd_bus` XOR `flt_swap_bus` and stays constant during a reply, as does `tx_status`.
- R11: A `cmd_valid` pulse while `tx_busy` is high is ignored. The running reply keeps its count and timing.
- R12: `tx_idx` is 0 on the first strobe of a reply and increases by one on each following strobe. Each strobe lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | One-cycle pulse: a valid command has ended |
| cmd_bus | input | 1 | Bus that carried the command (0 = A, 1 = B) |
| own_addr | input | 5 | Terminal's own address |
| exp_wc | input | 6 | Expected data word count (0 means 32) |
| status_flags | input | 11 | Low bits of the status word |
| flt_silent_a | input | 1 | Suppress reply to commands on bus A |
| flt_silent_b | input | 1 | Suppress reply to commands on bus B |
| flt_swap_bus | input | 1 | Reply on the opposite bus |
| flt_late_en | input | 1 | Use programmed response time |
| flt_late_us | input | 5 | Programmed response time in µs |
| flt_gap_sel | input | 2 | Dead time in µs to insert (0 = none) |
| flt_gap_pos | input | 6 | Word index after which dead time goes |
| flt_wc_adj | input | 6 | Signed word count adjustment |
| flt_addr_en | input | 1 | Substitute status address |
| flt_addr_val | input | 5 | Substituted status address |
| tx_start | output | 1 | One-cycle strobe: start sending a word |
| tx_busy | output | 1 | Reply in progress |
| tx_bus | output | 1 | Bus to transmit on (0 = A, 1 = B) |
| tx_idx | output | 6 | Index of the word strobed (0 = status) |
| tx_status | output | 16 | Status word to send |

## Verification
The bench builds the block with TICK_DIV=3 and keeps the defaults WORD_US=20 and NOMINAL_US=6. The small divider makes each microsecond three clock cycles. This brings the slowest cases within a short run: a 30 µs late response, a 33-word padded reply, and dead time at any word position. Every expected cycle count is still a whole number of ticks. With that divider, a gap error and a late error show up as exact cycle offsets and not as tolerance bands. This also lets the bench check the clamping at both ends of the response-time range and both ends of the count adjustment.

// File: rtl/rt_reply_pkg.sv
package rt_reply_pkg;

    localparam int ADDR_W   = 5;
    localparam int IDX_W    = 6;
    localparam int FLAG_W   = 11;
    localparam int STAT_W   = ADDR_W + FLAG_W;
    localparam int US_W     = 5;
    localparam int LATE_MIN = 2;
    localparam int LATE_MAX = 30;
    localparam int MAX_DATA = 32;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RESP_WAIT,
        ST_EMIT,
        ST_WORD_WAIT
    } seq_state_e;

    typedef struct packed {
        logic                    silent_a;
        logic                    silent_b;
        logic                    swap_bus;
        logic                    late_en;
        logic [US_W-1:0]         late_us;
        logic [1:0]              gap_sel;
        logic [IDX_W-1:0]        gap_pos;
        logic signed [IDX_W-1:0] wc_adj;
        logic                    addr_en;
        logic [ADDR_W-1:0]       addr_val;
    } fault_t;

    typedef struct packed {
        logic              silent;
        logic              bus;
        logic [US_W-1:0]   resp_us;
        logic [IDX_W-1:0]  last_idx;
        logic [STAT_W-1:0] status;
        logic [1:0]        dead_us;
        logic [IDX_W-1:0]  gap_pos;
    } plan_t;

endpackage

// File: rtl/rt_us_tick.sv
module rt_us_tick #(
    parameter int TICK_DIV = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int CW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = (cnt_q == LAST) && !clr;

endmodule

// File: rtl/rt_us_countdown.sv
module rt_us_countdown #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic             expire
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (tick && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expire = tick && !load && (cnt_q == CNT_W'(1));

endmodule

// File: rtl/rt_reply_plan.sv
module rt_reply_plan
    import rt_reply_pkg::*;
#(
    parameter int NOMINAL_US = 6
) (
    input  logic              cmd_bus,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic [IDX_W-1:0]  exp_wc,
    input  logic [FLAG_W-1:0] status_flags,
    input  fault_t            flt,
    output plan_t             plan
);
    logic signed [7:0] wc_base;
    logic signed [7:0] wc_adj_c;
    logic signed [7:0] wc_sum;
    logic [US_W-1:0]   late_c;

    always_comb begin
        wc_base  = (exp_wc == '0) ? 8'sd32 : $signed({2'b00, exp_wc});
        wc_adj_c = (flt.wc_adj > 6'sd1) ? 8'sd1
                                        : $signed({{2{flt.wc_adj[IDX_W-1]}}, flt.wc_adj});
        wc_sum   = wc_base + wc_adj_c;

        if (flt.late_us < US_W'(LATE_MIN)) begin
            late_c = US_W'(LATE_MIN);
        end else if (flt.late_us > US_W'(LATE_MAX)) begin
            late_c = US_W'(LATE_MAX);
        end else begin
            late_c = flt.late_us;
        end

        plan.silent   = cmd_bus ? flt.silent_b : flt.silent_a;
        plan.bus      = cmd_bus ^ flt.swap_bus;
        plan.resp_us  = flt.late_en ? late_c : US_W'(NOMINAL_US);
        plan.last_idx = wc_sum[7] ? '0 : wc_sum[IDX_W-1:0];
        plan.status   = {(flt.addr_en ? flt.addr_val : own_addr), status_flags};
        plan.dead_us  = flt.gap_sel;
        plan.gap_pos  = flt.gap_pos;
    end

endmodule

// File: rtl/rt_reply_fault_ctl.sv
module rt_reply_fault_ctl
    import rt_reply_pkg::*;
#(
    parameter int TICK_DIV   = 125,
    parameter int WORD_US    = 20,
    parameter int NOMINAL_US = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_bus,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic [IDX_W-1:0]  exp_wc,
    input  logic [FLAG_W-1:0] status_flags,
    input  logic              flt_silent_a,
    input  logic              flt_silent_b,
    input  logic              flt_swap_bus,
    input  logic              flt_late_en,
    input  logic [US_W-1:0]   flt_late_us,
    input  logic [1:0]        flt_gap_sel,
    input  logic [IDX_W-1:0]  flt_gap_pos,
    input  logic [IDX_W-1:0]  flt_wc_adj,
    input  logic              flt_addr_en,
    input  logic [ADDR_W-1:0] flt_addr_val,
    output logic              tx_start,
    output logic              tx_busy,
    output logic              tx_bus,
    output logic [IDX_W-1:0]  tx_idx,
    output logic [STAT_W-1:0] tx_status
);
    localparam int MAX_US = (WORD_US + 3 > LATE_MAX) ? WORD_US + 3 : LATE_MAX;
    localparam int CNT_W  = $clog2(MAX_US + 1);

    seq_state_e       state_q, state_d;
    fault_t           flt_in;
    plan_t            plan_c, plan_q;
    logic [IDX_W-1:0] idx_q;
    logic             accept, last_word;
    logic             tick, expire;
    logic             cd_load;
    logic [CNT_W-1:0] cd_val;

    assign flt_in = '{silent_a: flt_silent_a, silent_b: flt_silent_b,
                      swap_bus: flt_swap_bus, late_en: flt_late_en,
                      late_us: flt_late_us, gap_sel: flt_gap_sel,
                      gap_pos: flt_gap_pos, wc_adj: $signed(flt_wc_adj),
                      addr_en: flt_addr_en, addr_val: flt_addr_val};

    rt_reply_plan #(.NOMINAL_US(NOMINAL_US)) u_plan (
        .cmd_bus      (cmd_bus),
        .own_addr     (own_addr),
        .exp_wc       (exp_wc),
        .status_flags (status_flags),
        .flt          (flt_in),
        .plan         (plan_c)
    );

    assign accept    = cmd_valid && (state_q == ST_IDLE);
    assign last_word = (idx_q == plan_q.last_idx);

    rt_us_tick #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (accept),
        .tick  (tick)
    );

    always_comb begin
        cd_load = 1'b0;
        cd_val  = '0;
        if (accept && !plan_c.silent) begin
            cd_load = 1'b1;
            cd_val  = CNT_W'(plan_c.resp_us);
        end else if (state_q == ST_EMIT && !last_word) begin
            cd_load = 1'b1;
            cd_val  = CNT_W'(WORD_US)
                    + ((idx_q == plan_q.gap_pos) ? CNT_W'(plan_q.dead_us) : '0);
        end
    end

    rt_us_countdown #(.CNT_W(CNT_W)) u_cd (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cd_load),
        .load_val (cd_val),
        .tick     (tick),
        .expire   (expire)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (accept && !plan_c.silent) state_d = ST_RESP_WAIT;
            ST_RESP_WAIT: if (expire)                   state_d = ST_EMIT;
            ST_EMIT:      state_d = last_word ? ST_IDLE : ST_WORD_WAIT;
            ST_WORD_WAIT: if (expire)                   state_d = ST_EMIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            plan_q <= '0;
            idx_q  <= '0;
        end else if (accept) begin
            plan_q <= plan_c;
            idx_q  <= '0;
        end else if (state_q == ST_EMIT && !last_word) begin
            idx_q  <= idx_q + 1'b1;
        end
    end

    always_comb begin
        tx_start  = (state_q == ST_EMIT);
        tx_busy   = (state_q != ST_IDLE);
        tx_bus    = plan_q.bus;
        tx_idx    = idx_q;
        tx_status = plan_q.status;
    end

endmodule

// File: rtl/rt_reply_fault_ctl_chk.sv
module rt_reply_fault_ctl_chk #(
    parameter int TICK_DIV = 125
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_valid,
    input logic        tx_start,
    input logic        tx_busy,
    input logic        tx_bus,
    input logic [5:0]  tx_idx,
    input logic [15:0] tx_status
);
    logic [31:0] since_cmd;
    logic [5:0]  prev_idx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_cmd <= '0;
            prev_idx  <= '0;
        end else begin
            if (cmd_valid && !tx_busy) begin
                since_cmd <= '0;
            end else if (since_cmd != 32'hFFFF_FFFF) begin
                since_cmd <= since_cmd + 1'b1;
            end
            if (tx_start) begin
                prev_idx <= tx_idx;
            end
        end
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> !tx_start);

    assert_resp_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_start && tx_idx == 6'd0) |->
            (since_cmd >= 32'(2 * TICK_DIV) && since_cmd <= 32'(30 * TICK_DIV)));

    assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> tx_idx <= 6'd33);

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_busy && $past(tx_busy)) |-> ($stable(tx_bus) && $stable(tx_status)));

    assert_first_idx_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> tx_idx == 6'd0);

    assert_idx_step_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_start && tx_idx != 6'd0) |-> tx_idx == prev_idx + 6'd1);

    assert_single_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |=> !tx_start);

endmodule

bind rt_reply_fault_ctl rt_reply_fault_ctl_chk #(.TICK_DIV(TICK_DIV)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .tx_start  (tx_start),
    .tx_busy   (tx_busy),
    .tx_bus    (tx_bus),
    .tx_idx    (tx_idx),
    .tx_status (tx_status)
);

// File: tb/rt_reply_fault_ctl_bench.sv
module rt_reply_fault_ctl_bench;
    import rt_reply_pkg::*;

    localparam int DIV  = 3;
    localparam int WUS  = 20;
    localparam int NOM  = 6;
    localparam int WDOG = 190000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic cmd_bus = 1'b0;
    logic [4:0]  own_addr = '0;
    logic [5:0]  exp_wc = '0;
    logic [10:0] status_flags = '0;
    fault_t      cur_f = '0;
    logic tx_start, tx_busy, tx_bus;
    logic [5:0]  tx_idx;
    logic [15:0] tx_status;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;
    always @(posedge clk) cycles <= cycles + 1;

    rt_reply_fault_ctl #(.TICK_DIV(DIV), .WORD_US(WUS), .NOMINAL_US(NOM)) u_rt_reply_fault_ctl (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_bus(cmd_bus),
        .own_addr(own_addr), .exp_wc(exp_wc), .status_flags(status_flags),
        .flt_silent_a(cur_f.silent_a), .flt_silent_b(cur_f.silent_b),
        .flt_swap_bus(cur_f.swap_bus), .flt_late_en(cur_f.late_en),
        .flt_late_us(cur_f.late_us), .flt_gap_sel(cur_f.gap_sel),
        .flt_gap_pos(cur_f.gap_pos), .flt_wc_adj(cur_f.wc_adj),
        .flt_addr_en(cur_f.addr_en), .flt_addr_val(cur_f.addr_val),
        .tx_start(tx_start), .tx_busy(tx_busy), .tx_bus(tx_bus),
        .tx_idx(tx_idx), .tx_status(tx_status)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int e_data(input logic [5:0] wc, input fault_t f);
        int base = (wc == 6'd0) ? 32 : int'(wc);
        int adj  = int'(f.wc_adj);
        if (adj > 1) adj = 1;
        return (base + adj < 0) ? 0 : base + adj;
    endfunction

    function automatic int e_resp(input fault_t f);
        if (!f.late_en) return NOM;
        if (f.late_us < 5'd2) return 2;
        if (f.late_us > 5'd30) return 30;
        return int'(f.late_us);
    endfunction

    task automatic run_msg(input bit bus, input logic [5:0] wc, input fault_t f, input bit mid);
        int st [0:39];
        int ix [0:39];
        int bs [0:39];
        int sw [0:39];
        int n = 0;
        int t = 1;
        bit seen = 1'b0;
        bit done = 1'b0;
        bit silent = bus ? f.silent_b : f.silent_a;
        int resp = e_resp(f);
        int nd = e_data(wc, f);
        int mid_t = resp * DIV + 5;
        int exp_st = {(f.addr_en ? f.addr_val : own_addr), status_flags};
        cmd_bus = bus;
        exp_wc = wc;
        cur_f = f;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (!done && t < 3000) begin
            if (tx_start && n < 40) begin
                st[n] = t; ix[n] = int'(tx_idx); bs[n] = int'(tx_bus); sw[n] = int'(tx_status);
                n++;
            end
            if (tx_busy) seen = 1'b1;
            if (seen && !tx_busy) done = 1'b1;
            if (!seen && t > 40 * DIV) done = 1'b1;
            if (mid && t == mid_t) begin
                cmd_valid = 1'b1;
                exp_wc = 6'd2;
                cmd_bus = ~bus;
            end else begin
                cmd_valid = 1'b0;
            end
            @(negedge clk);
            t++;
        end
        cmd_valid = 1'b0;
        if (silent) begin
            chk("R9 strobes", n, 0);
            chk("R9 busy", int'(seen), 0);
        end else begin
            chk(f.late_en ? "R3 first delay" : "R2 first delay", (n > 0) ? st[0] : -1, resp * DIV + 1);
            chk((int'(f.wc_adj) + ((wc == 0) ? 32 : int'(wc)) < 0) ? "R7 word count" : "R6 word count", n, nd + 1);
            if (mid) chk("R11 count after ignored cmd", n, nd + 1);
            for (int k = 1; k < n; k++) begin
                int gap = ((k - 1) == int'(f.gap_pos)) ? int'(f.gap_sel) : 0;
                chk((gap != 0) ? "R5 spacing" : "R4 spacing", st[k] - st[k-1], (WUS + gap) * DIV);
                chk("R12 index", ix[k], k);
            end
            if (n > 0) begin
                chk("R12 first index", ix[0], 0);
                chk("R10 bus", bs[0], int'(bus ^ f.swap_bus));
                chk("R8 status", sw[0], exp_st);
            end
        end
        repeat (3) @(negedge clk);
    endtask

    function automatic fault_t clean();
        fault_t f = '0;
        f.gap_pos = 6'd63;
        return f;
    endfunction

    initial begin
        while (cycles < WDOG && !finished) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected<%0d", cycles, WDOG);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        fault_t f;
        void'($urandom(32'd24680));
        own_addr = 5'd13;
        status_flags = 11'h2A5;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy", int'(tx_busy), 0);
        chk("R1 start", int'(tx_start), 0);
        chk("R1 idx", int'(tx_idx), 0);

        f = clean(); run_msg(1'b0, 6'd3, f, 1'b0);
        f = clean(); f.late_en = 1; f.late_us = 5'd2;  run_msg(1'b1, 6'd1, f, 1'b0);
        f = clean(); f.late_en = 1; f.late_us = 5'd30; run_msg(1'b0, 6'd1, f, 1'b0);
        f = clean(); f.late_en = 1; f.late_us = 5'd0;  run_msg(1'b0, 6'd1, f, 1'b0);
        f = clean(); f.late_en = 1; f.late_us = 5'd31; run_msg(1'b1, 6'd1, f, 1'b0);
        f = clean(); f.wc_adj = 6'(-32); run_msg(1'b0, 6'd0, f, 1'b0);
        f = clean(); f.wc_adj = 6'(-5);  run_msg(1'b0, 6'd3, f, 1'b0);
        f = clean(); f.wc_adj = 6'd1;    run_msg(1'b1, 6'd32, f, 1'b0);
        f = clean(); f.wc_adj = 6'd9;    run_msg(1'b0, 6'd2, f, 1'b0);
        for (int g = 1; g < 4; g++) begin
            f = clean(); f.gap_sel = 2'(g); f.gap_pos = 6'(g - 1); run_msg(1'b0, 6'd4, f, 1'b0);
        end
        f = clean(); f.silent_a = 1; run_msg(1'b0, 6'd2, f, 1'b0);
        f = clean(); f.silent_a = 1; run_msg(1'b1, 6'd2, f, 1'b0);
        f = clean(); f.silent_b = 1; run_msg(1'b1, 6'd2, f, 1'b0);
        f = clean(); f.silent_b = 1; run_msg(1'b0, 6'd2, f, 1'b0);
        f = clean(); f.silent_a = 1; f.silent_b = 1; run_msg(1'b1, 6'd2, f, 1'b0);
        f = clean(); f.swap_bus = 1; run_msg(1'b0, 6'd1, f, 1'b0);
        f = clean(); f.swap_bus = 1; run_msg(1'b1, 6'd1, f, 1'b0);
        f = clean(); f.addr_en = 1; f.addr_val = 5'd0;  run_msg(1'b0, 6'd1, f, 1'b0);
        f = clean(); f.addr_en = 1; f.addr_val = 5'd31; run_msg(1'b1, 6'd1, f, 1'b0);
        f = clean(); run_msg(1'b0, 6'd5, f, 1'b1);

        for (int r = 0; r < 30; r++) begin
            f = '0;
            f.silent_a = ($urandom % 6) == 0;
            f.silent_b = ($urandom % 6) == 0;
            f.swap_bus = $urandom % 2;
            f.late_en  = $urandom % 2;
            f.late_us  = 5'($urandom % 32);
            f.gap_sel  = 2'($urandom % 4);
            f.gap_pos  = 6'($urandom % 6);
            f.wc_adj   = 6'(int'($urandom % 8) - 6);
            f.addr_en  = $urandom % 2;
            f.addr_val = 5'($urandom % 32);
            own_addr     = 5'($urandom % 32);
            status_flags = 11'($urandom % 2048);
            run_msg(1'($urandom % 2), 6'(1 + $urandom % 8), f, 1'($urandom % 4 == 0));
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule